// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit sits beside the decode stage of a five-stage in-order integer pipeline. Each cycle it looks at the source register numbers of the instruction in decode and compares them with the destinations of the two older instructions still in flight. One of them sits in the ID/EX register and the other in the EX/MEM register. From those comparisons it picks, for each ALU operand, where the operand will come from once the instruction reaches execute. The choices are the register file, the EX/MEM result or the MEM/WB result. It registers that choice so that the choice is valid while the consumer executes.

When the instruction one step ahead is a load whose destination the decode instruction reads, no bypass can deliver the data in time. The unit then raises a stall for exactly that cycle. The stall freezes the program counter and the IF/ID register and turns the slot entering execute into a bubble. On the following cycle the load has moved on by one stage, and the same comparison resolves the dependence through the MEM/WB path. A producer three instructions ahead needs no action, because the register file writes early in the cycle and reads late.

Top module: `fwd_hazard_unit`

## Requirements
- R1: If a used source of the decode instruction equals the ID/EX destination (write enabled, non-zero, not a load), that operand's select on the next clock edge is 2'b10 (EX/MEM result).
- R2: If a used source equals the EX/MEM destination (write enabled, non-zero) and R1 does not apply, that operand's select on the next clock edge is 2'b01 (MEM/WB result).
- R3: A source that matches no write-enabled destination gets select 2'b00 (register file), including a producer whose write enable is low.
- R4: If a used source equals the destination of a load in ID/EX, stall is high in that same cycle, with pc_we=0, ifid_we=0 and ex_bubble=1, and both selects on the next edge are 2'b00.
- R5: Once the load has moved into EX/MEM and a bubble occupies ID/EX, stall is low and the held consumer gets select 2'b01, so exactly one bubble is paid.
- R6: A load in EX/MEM whose destination is read by the decode instruction causes no stall and gives select 2'b01.
- R7: Register 0 never produces a non-zero select and never causes a stall.
- R8: When both ID/EX and EX/MEM match the same source, select 2'b10 wins.
- R9: The two operands are decided independently, each with its own select.
- R10: A source field marked as unused never produces a bypass or a stall.
- R11: While rst_n is low, both selects are 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_rs1 | input | 5 | First source register of the decode instruction |
| id_rs2 | input | 5 | Second source register of the decode instruction |
| id_rs1_used | input | 1 | First source is actually read |
| id_rs2_used | input | 1 | Second source is actually read |
| idex_rd | input | 5 | Destination held in ID/EX |
| idex_regwrite | input | 1 | ID/EX instruction writes a register |
| idex_memread | input | 1 | ID/EX instruction is a load |
| exmem_rd | input | 5 | Destination held in EX/MEM |
| exmem_regwrite | input | 1 | EX/MEM instruction writes a register |
| fwd_a | output | 2 | Operand A source for the instruction in execute (00 RF, 10 EX/MEM, 01 MEM/WB) |
| fwd_b | output | 2 | Operand B source for the instruction in execute |
| stall | output | 1 | Load-use interlock active this cycle |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | IF/ID register write enable |
| ex_bubble | output | 1 | Insert a NOP into ID/EX |

## Verification
The bench goes after matches on register 0 and expects no bypass there; a design that skipped the zero test would route stale data and stall on writes to x0. It makes both older stages match one source, where reversed priority would hand execute an outdated value. It also drives sources that look like matches but are marked unused or have their write enable low, where a careless design stalls for nothing. A two-step load-use sequence checks that the bubble carries a register-file select, that the stall drops after one cycle, and that the held consumer then reads from MEM/WB. A unit that stalled twice or selected EX/MEM there would fail that sequence.

// File: rtl/fwdh_pkg.sv
package fwdh_pkg;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } opnd_src_e;

  // The nearer producer is the newer value and therefore wins.
  function automatic opnd_src_e pick_src(input logic near_hit, input logic far_hit);
    if (near_hit)     return SRC_EXMEM;
    else if (far_hit) return SRC_MEMWB;
    else              return SRC_REGFILE;
  endfunction

endpackage

// File: rtl/fwdh_operand.sv
module fwdh_operand #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic [AW-1:0] near_rd,
  input  logic          near_we,
  input  logic          near_ld,
  input  logic [AW-1:0] far_rd,
  input  logic          far_we,
  input  logic          hold,
  output logic [1:0]    sel_q,
  output logic          load_hit
);
  import fwdh_pkg::*;

  function automatic logic dep_hit(input logic [AW-1:0] s, input logic u,
                                   input logic [AW-1:0] d, input logic we);
    return u && we && (d != '0) && (s == d);
  endfunction

  logic      near_hit;
  logic      far_hit;
  opnd_src_e sel_next;

  assign near_hit = dep_hit(src, used, near_rd, near_we);
  assign far_hit  = dep_hit(src, used, far_rd, far_we);
  assign load_hit = near_hit && near_ld;
  assign sel_next = pick_src(near_hit, far_hit);

  always_ff @(posedge clk) begin
    if (!rst_n)    sel_q <= SRC_REGFILE;
    else if (hold) sel_q <= SRC_REGFILE;
    else           sel_q <= sel_next;
  end

  AST_NEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (near_hit && far_hit && !hold) |=> (sel_q == SRC_EXMEM)); // R8

  AST_FAR_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    (far_hit && !near_hit && !hold) |=> (sel_q == SRC_MEMWB)); // R2

  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && (src == '0 || !used)) |=> (sel_q == SRC_REGFILE)); // R7

  AST_NO_LOAD_HIT_R0: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |-> (src != '0 && used)); // R10

endmodule

// File: rtl/fwdh_interlock.sv
module fwdh_interlock #(
  parameter int NOPS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NOPS-1:0] load_hits,
  input  logic            near_ld,
  output logic            stall,
  output logic            pc_we,
  output logic            ifid_we,
  output logic            ex_bubble
);
  assign stall     = |load_hits;
  assign pc_we     = !stall;
  assign ifid_we   = !stall;
  assign ex_bubble = stall;

  AST_STALL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> near_ld); // R4

endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] id_rs1,
  input  logic [AW-1:0] id_rs2,
  input  logic          id_rs1_used,
  input  logic          id_rs2_used,
  input  logic [AW-1:0] idex_rd,
  input  logic          idex_regwrite,
  input  logic          idex_memread,
  input  logic [AW-1:0] exmem_rd,
  input  logic          exmem_regwrite,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          pc_we,
  output logic          ifid_we,
  output logic          ex_bubble
);
  localparam int NOPS = 2;

  logic [AW-1:0]   srcs [NOPS];
  logic            uses [NOPS];
  logic [1:0]      sels [NOPS];
  logic [NOPS-1:0] load_hits;

  assign srcs[0] = id_rs1;
  assign srcs[1] = id_rs2;
  assign uses[0] = id_rs1_used;
  assign uses[1] = id_rs2_used;

  for (genvar g = 0; g < NOPS; g++) begin : g_opnd
    fwdh_operand #(.AW(AW)) u_opnd (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (srcs[g]),
      .used     (uses[g]),
      .near_rd  (idex_rd),
      .near_we  (idex_regwrite),
      .near_ld  (idex_memread),
      .far_rd   (exmem_rd),
      .far_we   (exmem_regwrite),
      .hold     (stall),
      .sel_q    (sels[g]),
      .load_hit (load_hits[g])
    );
  end

  fwdh_interlock #(.NOPS(NOPS)) u_ilk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_hits (load_hits),
    .near_ld   (idex_memread),
    .stall     (stall),
    .pc_we     (pc_we),
    .ifid_we   (ifid_we),
    .ex_bubble (ex_bubble)
  );

  assign fwd_a = sels[0];
  assign fwd_b = sels[1];

  AST_BUBBLE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fwd_a == 2'b00 && fwd_b == 2'b00)); // R4

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'b11) && (fwd_b != 2'b11)); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (fwd_a == 2'b00 && fwd_b == 2'b00)); // R11

endmodule

// File: tb/fwd_hazard_unit_bench.sv
`timescale 1ns/1ps
module fwd_hazard_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] id_rs1 = '0, id_rs2 = '0, idex_rd = '0, exmem_rd = '0;
  logic       id_rs1_used = 1'b0, id_rs2_used = 1'b0;
  logic       idex_regwrite = 1'b0, idex_memread = 1'b0, exmem_regwrite = 1'b0;
  logic [1:0] fwd_a, fwd_b;
  logic       stall, pc_we, ifid_we, ex_bubble;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fwd_hazard_unit u_fwd_hazard_unit (
    .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .id_rs1_used(id_rs1_used), .id_rs2_used(id_rs2_used),
    .idex_rd(idex_rd), .idex_regwrite(idex_regwrite), .idex_memread(idex_memread),
    .exmem_rd(exmem_rd), .exmem_regwrite(exmem_regwrite),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .pc_we(pc_we),
    .ifid_we(ifid_we), .ex_bubble(ex_bubble)
  );

  // {rs1, rs2, u1, u2, idex_rd, idex_we, idex_ld, exmem_rd, exmem_we, stall, a, b}
  localparam int NV = 11;
  localparam logic [29:0] VEC [NV] = '{
    {5'd1,  5'd0,  1'b1, 1'b0, 5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 2'b10, 2'b00}, // R1
    {5'd0,  5'd2,  1'b0, 1'b1, 5'd0,  1'b0, 1'b0, 5'd2,  1'b1, 1'b0, 2'b00, 2'b01}, // R2
    {5'd3,  5'd4,  1'b1, 1'b1, 5'd5,  1'b1, 1'b0, 5'd6,  1'b1, 1'b0, 2'b00, 2'b00}, // R3
    {5'd3,  5'd3,  1'b1, 1'b1, 5'd3,  1'b0, 1'b1, 5'd3,  1'b0, 1'b0, 2'b00, 2'b00}, // R3 we low
    {5'd0,  5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 1'b0, 2'b00, 2'b00}, // R7
    {5'd7,  5'd0,  1'b1, 1'b0, 5'd7,  1'b1, 1'b0, 5'd7,  1'b1, 1'b0, 2'b10, 2'b00}, // R8
    {5'd8,  5'd9,  1'b1, 1'b1, 5'd8,  1'b1, 1'b0, 5'd9,  1'b1, 1'b0, 2'b10, 2'b01}, // R9
    {5'd10, 5'd10, 1'b0, 1'b0, 5'd10, 1'b1, 1'b1, 5'd10, 1'b1, 1'b0, 2'b00, 2'b00}, // R10
    {5'd4,  5'd11, 1'b1, 1'b1, 5'd1,  1'b1, 1'b0, 5'd11, 1'b1, 1'b0, 2'b00, 2'b01}, // R6
    {5'd12, 5'd2,  1'b1, 1'b1, 5'd12, 1'b1, 1'b1, 5'd0,  1'b0, 1'b1, 2'b00, 2'b00}, // R4
    {5'd13, 5'd13, 1'b1, 1'b1, 5'd13, 1'b1, 1'b1, 5'd13, 1'b1, 1'b1, 2'b00, 2'b00}  // R4 both
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [29:0] v);
    id_rs1 = v[29:25]; id_rs2 = v[24:20];
    id_rs1_used = v[19]; id_rs2_used = v[18];
    idex_rd = v[17:13]; idex_regwrite = v[12]; idex_memread = v[11];
    exmem_rd = v[10:6]; exmem_regwrite = v[5];
  endtask

  task automatic chk_stall(input string req, input logic exp);
    chk({req, " stall"}, 32'(stall), 32'(exp));
    chk({req, " pc_we"}, 32'(pc_we), 32'(!exp));
    chk({req, " ifid_we"}, 32'(ifid_we), 32'(!exp));
    chk({req, " ex_bubble"}, 32'(ex_bubble), 32'(exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset holds selects at register file despite matching inputs
    drive(VEC[6]);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 fwd_a", 32'(fwd_a), 32'h0);
    chk("R11 fwd_b", 32'(fwd_b), 32'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      chk_stall($sformatf("vec%0d", i), VEC[i][4]);
      @(negedge clk);
      chk($sformatf("vec%0d fwd_a", i), 32'(fwd_a), 32'(VEC[i][3:2]));
      chk($sformatf("vec%0d fwd_b", i), 32'(fwd_b), 32'(VEC[i][1:0]));
    end

    // R4/R5: load x5 then add using x5, modelled cycle by cycle
    @(negedge clk);
    drive({5'd5, 5'd6, 1'b1, 1'b1, 5'd5, 1'b1, 1'b1, 5'd9, 1'b1, 1'b0, 2'b00, 2'b00});
    #1 chk_stall("R4 load-use", 1'b1);
    @(negedge clk);
    chk("R4 bubble fwd_a", 32'(fwd_a), 32'h0);
    // bubble now in ID/EX, load in EX/MEM, consumer held in ID
    drive({5'd5, 5'd6, 1'b1, 1'b1, 5'd0, 1'b0, 1'b0, 5'd5, 1'b1, 1'b0, 2'b00, 2'b00});
    #1 chk_stall("R5 released", 1'b0);
    @(negedge clk);
    chk("R5 fwd_a", 32'(fwd_a), 32'h1);
    chk("R5 fwd_b", 32'(fwd_b), 32'h0);

    // R7: zero destination with a zero source, load in ID/EX, on operand B only
    drive({5'd3, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b1, 5'd0, 1'b1, 1'b0, 2'b00, 2'b00});
    #1 chk_stall("R7 no stall", 1'b0);
    @(negedge clk);
    chk("R7 fwd_b", 32'(fwd_b), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule